// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers level-sensitive interrupt requests from two groups of sources and presents one request line to a processor. Forty primary lines, split into a full 32-bit bank and an 8-bit bank, each latch a pending bit and carry an enable bit. Thirty-two secondary lines have their own pending and enable state. Their enabled, pending summary is folded into primary line 0, so software reaches every secondary source through that one line.

Software works through a 32-bit register bus with separate read and write strobes. Enables never take a direct write. One address turns bits on and a second address turns bits off, so one line can be changed without a read-modify-write. Pending bits are cleared by writing ones. A source that is still held high latches again on the next clock. A priority index register names the winning line, and a table of routing registers holds one channel number for each primary line.

Top module: `cascade_irq_top`

## Requirements
- R1: After reset every enable and pending bit is 0, `cpuIrq` is 0, and the routing register of line i reads back i.
- R2: Writing to enable-set (0x20 for lines 0-31, 0x24 for lines 32-39) enables each line whose data bit is 1, and 0 bits change nothing. Enables read back at 0x20/0x24 and at 0x30/0x34.
- R3: Writing to enable-clear (0x30 / 0x34) disables each line whose data bit is 1, and 0 bits change nothing.
- R4: A primary pending bit latches on any clock edge where its source is high, whether or not the line is enabled. Pending bits read at 0x10/0x14. Writing a 1 to a bit there clears it, and the bit latches again on the next edge if the source is still high.
- R5: The second bank implements only bits 7:0, which map to lines 32-39. Higher write bits are dropped and those bits read as 0.
- R6: The secondary registers work as follows. Pending reads at 0x80 and at 0x88. Writing 1s to 0x88 clears pending bits. Writing 1s to 0x90 sets enables and writing 1s to 0x98 clears them. Enables read at 0x90 and 0x98.
- R7: Primary line 0 is driven by the OR of its own input and of all enabled pending secondary lines. A pending secondary line that is not enabled does not drive it.
- R8: Register 0x40 returns in bits 5:0 the lowest-numbered line from 1 to 39 that is both enabled and pending. It returns 0 when no such line exists, which includes the case where only line 0 is active. Bits 31:6 read 0.
- R9: `cpuIrq` equals the OR of all enabled pending primary lines, delayed by one clock.
- R10: The routing register for line i is at 0x200 + 4*i. It stores the low 6 bits of the write data and reads them back.
- R11: `busRdata` changes only on a clock edge where `busRe` is high, and then shows the addressed register. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busAddr | input | 12 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| priIrq | input | 40 | Primary level sources |
| secIrq | input | 32 | Secondary level sources |
| cpuIrq | output | 1 | Registered request to the processor |

## Verification
The bench clears a pending bit while its source is still high and expects the bit to return. A design that cleared it for good would lose a level request. It writes all ones to the 8-bit bank and expects only the low byte to stick, which catches a bank whose register is too wide. It raises a secondary source before enabling it and expects line 0 to stay quiet until the enable arrives, which exposes a cascade that ignores the secondary enables. The priority index is read with line 0, line 9 and line 35 active in different mixes. An encoder that favoured high numbers, or that reported line 0, would return the wrong number.

// File: rtl/cascade_irq_pkg.sv
package cascade_irq_pkg;
  localparam int DATA_W     = 32;
  localparam int PRI_LINES  = 40;
  localparam int SEC_LINES  = 32;
  localparam int ADDR_W     = 12;
  localparam int CHAN_W     = 6;
  localparam int LINE_IDX_W = 6;
  localparam int NUM_BANKS  = (PRI_LINES + DATA_W - 1) / DATA_W;
  localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  typedef enum logic [2:0] {
    RD_NONE, RD_PEND, RD_EN, RD_SEC_PEND, RD_SEC_EN, RD_PRIO, RD_CHAN
  } rdSel_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0]  priClr;
    logic [NUM_BANKS-1:0]  priSet;
    logic [NUM_BANKS-1:0]  priDis;
    logic                  secClr;
    logic                  secSet;
    logic                  secDis;
    logic                  chanWr;
    logic [LINE_IDX_W-1:0] lineIdx;
    logic                  rdEn;
    rdSel_e                rdSel;
    logic [BANK_W-1:0]     bankSel;
  } strobe_t;
endpackage

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cascade_irq_pkg::*;
#(
  parameter int NUM_PRI = PRI_LINES
) (
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] SEC_BASE  = ADDR_W'(12'h080);
  localparam logic [ADDR_W-1:0] SEC_END   = ADDR_W'(12'h0A0);
  localparam logic [ADDR_W-1:0] PRIO_ADDR = ADDR_W'(12'h040);
  localparam logic [ADDR_W-1:0] CHAN_BASE = ADDR_W'(12'h200);
  localparam logic [ADDR_W-1:0] CHAN_END  = ADDR_W'(12'h200 + 4 * NUM_PRI);

  logic [2:0]        regNo;
  logic [1:0]        bankRaw;
  logic [1:0]        secReg;
  logic [ADDR_W-1:0] chanOff;

  assign regNo   = busAddr[6:4];
  assign bankRaw = busAddr[3:2];
  assign secReg  = busAddr[4:3];
  assign chanOff = busAddr - CHAN_BASE;

  always_comb begin
    stb         = '0;
    stb.rdSel   = RD_NONE;
    stb.rdEn    = busRe;
    stb.bankSel = BANK_W'(bankRaw);
    if (busAddr == PRIO_ADDR) begin
      stb.rdSel = RD_PRIO;
    end else if (busAddr < SEC_BASE) begin
      if (busAddr[1:0] == 2'b00 && int'(bankRaw) < NUM_BANKS) begin
        unique case (regNo)
          3'd1: begin
            stb.rdSel = RD_PEND;
            stb.priClr[bankRaw] = busWe;
          end
          3'd2: begin
            stb.rdSel = RD_EN;
            stb.priSet[bankRaw] = busWe;
          end
          3'd3: begin
            stb.rdSel = RD_EN;
            stb.priDis[bankRaw] = busWe;
          end
          default: stb.rdSel = RD_NONE;
        endcase
      end
    end else if (busAddr < SEC_END) begin
      if (busAddr[2:0] == 3'b000) begin
        unique case (secReg)
          2'd0: stb.rdSel = RD_SEC_PEND;
          2'd1: begin
            stb.rdSel  = RD_SEC_PEND;
            stb.secClr = busWe;
          end
          2'd2: begin
            stb.rdSel  = RD_SEC_EN;
            stb.secSet = busWe;
          end
          default: begin
            stb.rdSel  = RD_SEC_EN;
            stb.secDis = busWe;
          end
        endcase
      end
    end else if (busAddr >= CHAN_BASE && busAddr < CHAN_END && busAddr[1:0] == 2'b00) begin
      stb.rdSel   = RD_CHAN;
      stb.chanWr  = busWe;
      stb.lineIdx = LINE_IDX_W'(chanOff >> 2);
    end
  end
endmodule

// File: rtl/cascade_irq_datapath.sv
module cascade_irq_datapath
  import cascade_irq_pkg::*;
#(
  parameter int NUM_PRI = PRI_LINES,
  parameter int NUM_SEC = SEC_LINES
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_PRI-1:0] priIrq,
  input  logic [NUM_SEC-1:0] secIrq,
  output logic [DATA_W-1:0]  rdata,
  output logic               cpuIrq
);
  logic [NUM_PRI-1:0] priPend, priEn, priActive, priSrc;
  logic [NUM_PRI-1:0] clrMask, setMask, disMask;
  logic [NUM_SEC-1:0] secPend, secEn;
  logic [CHAN_W-1:0]  chanMap [NUM_PRI];
  logic               cascadeReq;
  logic [LINE_IDX_W-1:0] winner;
  logic [DATA_W-1:0]  rdNext;

  assign cascadeReq = |(secPend & secEn);
  assign priActive  = priPend & priEn;

  always_comb begin
    priSrc    = priIrq;
    priSrc[0] = priIrq[0] | cascadeReq;
    for (int i = 0; i < NUM_PRI; i++) begin
      clrMask[i] = stb.priClr[i / DATA_W] & wdata[i % DATA_W];
      setMask[i] = stb.priSet[i / DATA_W] & wdata[i % DATA_W];
      disMask[i] = stb.priDis[i / DATA_W] & wdata[i % DATA_W];
    end
  end

  // Lowest numbered active line above 0 wins; 0 otherwise.
  always_comb begin
    winner = '0;
    for (int i = NUM_PRI - 1; i >= 1; i--) begin
      if (priActive[i]) winner = LINE_IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priPend <= '0;
      priEn   <= '0;
      secPend <= '0;
      secEn   <= '0;
      cpuIrq  <= 1'b0;
    end else begin
      priPend <= (priPend & ~clrMask) | priSrc;
      priEn   <= (priEn | setMask) & ~disMask;
      secPend <= (secPend & ~({NUM_SEC{stb.secClr}} & wdata[NUM_SEC-1:0])) | secIrq;
      secEn   <= (secEn | ({NUM_SEC{stb.secSet}} & wdata[NUM_SEC-1:0]))
                 & ~({NUM_SEC{stb.secDis}} & wdata[NUM_SEC-1:0]);
      cpuIrq  <= |priActive;
    end
  end

  generate
    for (genvar g = 0; g < NUM_PRI; g++) begin : gChan
      always_ff @(posedge clk) begin
        if (!rstN)
          chanMap[g] <= CHAN_W'(g);
        else if (stb.chanWr && int'(stb.lineIdx) == g)
          chanMap[g] <= wdata[CHAN_W-1:0];
      end
    end
  endgenerate

  always_comb begin
    rdNext = '0;
    unique case (stb.rdSel)
      RD_PEND, RD_EN: begin
        for (int i = 0; i < NUM_PRI; i++) begin
          if (i / DATA_W == int'(stb.bankSel))
            rdNext[i % DATA_W] = (stb.rdSel == RD_PEND) ? priPend[i] : priEn[i];
        end
      end
      RD_SEC_PEND: rdNext[NUM_SEC-1:0] = secPend;
      RD_SEC_EN:   rdNext[NUM_SEC-1:0] = secEn;
      RD_PRIO:     rdNext[LINE_IDX_W-1:0] = winner;
      RD_CHAN:     rdNext[CHAN_W-1:0] = chanMap[stb.lineIdx];
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rdata <= '0;
    else if (stb.rdEn) rdata <= rdNext;
  end
endmodule

// File: rtl/cascade_irq_top.sv
module cascade_irq_top
  import cascade_irq_pkg::*;
#(
  parameter int NUM_PRI = PRI_LINES,
  parameter int NUM_SEC = SEC_LINES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWe,
  input  logic               busRe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_PRI-1:0] priIrq,
  input  logic [NUM_SEC-1:0] secIrq,
  output logic               cpuIrq
);
  strobe_t stb;

  cascade_irq_ctrl #(.NUM_PRI(NUM_PRI)) u_ctrl (
    .busWe  (busWe),
    .busRe  (busRe),
    .busAddr(busAddr),
    .stb    (stb)
  );

  cascade_irq_datapath #(.NUM_PRI(NUM_PRI), .NUM_SEC(NUM_SEC)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wdata (busWdata),
    .priIrq(priIrq),
    .secIrq(secIrq),
    .rdata (busRdata),
    .cpuIrq(cpuIrq)
  );
endmodule

// File: rtl/cascade_irq_checker.sv
module cascade_irq_checker #(
  parameter int NUM_PRI = 40
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWe,
  input logic               busRe,
  input logic [11:0]        busAddr,
  input logic [31:0]        busWdata,
  input logic [31:0]        busRdata,
  input logic [NUM_PRI-1:0] priIrq,
  input logic [NUM_PRI-1:0] priPend,
  input logic [NUM_PRI-1:0] priEn,
  input logic               cpuIrq
);
  localparam int HI_BITS = NUM_PRI - 32;

  assert_irq_delay_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> cpuIrq == $past(|(priPend & priEn)));

  assert_en_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 12'h020) |=> &(priEn[31:0] | ~$past(busWdata)));

  assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 12'h030) |=> ~|(priEn[31:0] & $past(busWdata)));

  assert_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((priPend[NUM_PRI-1:1] & $past(priIrq[NUM_PRI-1:1])) == $past(priIrq[NUM_PRI-1:1])));

  assert_bank_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == 12'h024) |=> busRdata[31:HI_BITS] == '0);

  assert_prio_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == 12'h040) |=> (busRdata[31:6] == '0) && (int'(busRdata[5:0]) < NUM_PRI));
endmodule

bind cascade_irq_top cascade_irq_checker #(.NUM_PRI(NUM_PRI)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busWe   (busWe),
  .busRe   (busRe),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .priIrq  (priIrq),
  .priPend (u_dp.priPend),
  .priEn   (u_dp.priEn),
  .cpuIrq  (cpuIrq)
);

// File: tb/cascade_irq_top_bench.sv
module cascade_irq_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [39:0] priIrq = '0;
  logic [31:0] secIrq = '0;
  logic        cpuIrq;

  int nChk = 0;
  int nBad = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSampled = 1'b0;

  always #2.5 clk = ~clk;

  cascade_irq_top u_cascade_irq_top (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .priIrq(priIrq), .secIrq(secIrq),
    .cpuIrq(cpuIrq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: one registered read result per sampled strobe.
  always @(posedge clk) rdSampled <= busRe;
  always @(negedge clk) begin
    if (rdSampled) begin
      if (expQ.size() == 0) check("R11 unexpected read", busRdata, 32'hx);
      else check(tagQ.pop_front(), busRdata, expQ.pop_front());
    end
  end

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    busRe = 1'b1; busAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkIrq(logic exp, string tag);
    idle(2);
    check(tag, {31'b0, cpuIrq}, {31'b0, exp});
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkIrq(1'b0, "R1 cpuIrq after reset");
    busRead(12'h020, 32'h0, "R1 bank0 enables");
    busRead(12'h024, 32'h0, "R1 bank1 enables");
    busRead(12'h010, 32'h0, "R1 bank0 pending");
    busRead(12'h090, 32'h0, "R1 secondary enables");
    busRead(12'h040, 32'h0, "R1 priority index");
    busRead(12'h214, 32'd5, "R1 route line 5");
    busRead(12'h29C, 32'd39, "R1 route line 39");
    // R2 / R3 enables
    busWrite(12'h020, 32'h0000_00A0);
    busRead(12'h020, 32'h0000_00A0, "R2 set lines 5,7");
    busWrite(12'h020, 32'h0);
    busRead(12'h020, 32'h0000_00A0, "R2 zero bits no effect");
    busWrite(12'h030, 32'h0000_0080);
    busRead(12'h030, 32'h0000_0020, "R3 clear line 7");
    busWrite(12'h030, 32'h0);
    busRead(12'h020, 32'h0000_0020, "R3 zero bits no effect");
    // R4 latching, R9 output
    priIrq[5] = 1'b1; priIrq[9] = 1'b1;
    busRead(12'h010, 32'h0000_0220, "R4 latch enabled and disabled lines");
    checkIrq(1'b1, "R9 cpuIrq with line 5 active");
    busRead(12'h040, 32'd5, "R8 index line 5");
    priIrq[5] = 1'b0;
    busRead(12'h010, 32'h0000_0220, "R4 pending held after source drops");
    busWrite(12'h010, 32'h0000_0020);
    busRead(12'h010, 32'h0000_0200, "R4 clear line 5");
    checkIrq(1'b0, "R9 cpuIrq drops after clear");
    busWrite(12'h010, 32'h0000_0200);
    busRead(12'h010, 32'h0000_0200, "R4 relatch while source high");
    // R8 priority with bank 1
    busWrite(12'h020, 32'h0000_0200);
    busWrite(12'h024, 32'h0000_0008);
    priIrq[35] = 1'b1;
    busRead(12'h040, 32'd9, "R8 line 9 beats line 35");
    busWrite(12'h030, 32'h0000_0200);
    busRead(12'h040, 32'd35, "R8 line 35 after line 9 disabled");
    // R5 bank width
    busWrite(12'h024, 32'hFFFF_FFFF);
    busRead(12'h024, 32'h0000_00FF, "R5 bank1 low byte only");
    busRead(12'h014, 32'h0000_0008, "R5 bank1 pending line 35");
    busWrite(12'h034, 32'hFFFF_FFF7);
    busRead(12'h034, 32'h0000_0008, "R5 bank1 clear keeps line 35");
    // cleanup
    priIrq = '0;
    busWrite(12'h030, 32'hFFFF_FFFF);
    busWrite(12'h034, 32'hFFFF_FFFF);
    busWrite(12'h010, 32'hFFFF_FFFF);
    busWrite(12'h014, 32'hFFFF_FFFF);
    checkIrq(1'b0, "R9 cpuIrq idle after cleanup");
    busRead(12'h040, 32'd0, "R8 zero when nothing pending");
    // R6 / R7 secondary cascade
    secIrq[3] = 1'b1;
    busRead(12'h080, 32'h0000_0008, "R6 secondary pending");
    idle(2);
    busRead(12'h010, 32'h0, "R7 disabled secondary does not cascade");
    busWrite(12'h090, 32'h0000_0008);
    busRead(12'h090, 32'h0000_0008, "R6 secondary enable set");
    idle(2);
    busRead(12'h010, 32'h0000_0001, "R7 cascade pends line 0");
    checkIrq(1'b0, "R9 line 0 still disabled");
    busWrite(12'h020, 32'h0000_0001);
    checkIrq(1'b1, "R9 cascade raises cpuIrq");
    busRead(12'h040, 32'd0, "R8 only cascade reads 0");
    priIrq[12] = 1'b1;
    busWrite(12'h020, 32'h0000_1000);
    busRead(12'h040, 32'd12, "R8 line 12 beats cascade");
    secIrq[3] = 1'b0;
    busWrite(12'h088, 32'h0000_0008);
    busRead(12'h088, 32'h0, "R6 secondary pending cleared");
    busWrite(12'h010, 32'h0000_0001);
    busRead(12'h010, 32'h0000_1000, "R7 line 0 stays clear after cascade gone");
    busWrite(12'h098, 32'h0000_0008);
    busRead(12'h098, 32'h0, "R6 secondary enable cleared");
    // R10 routing, R11 unmapped
    busWrite(12'h21C, 32'h003F_FFC2);
    busRead(12'h21C, 32'h0000_0002, "R10 route line 7 low bits");
    busRead(12'h218, 32'd6, "R10 neighbour route untouched");
    busRead(12'h100, 32'h0, "R11 unmapped reads 0");
    idle(2);
    check("R11 data held without strobe", busRdata, 32'h0);
    finishRun();
  end
endmodule